// File: doc/BRIEF.md
# Performance Counter Update Strobe Selector

This block generates the update-and-clear strobe that a group of per-port performance counters uses to snapshot and reset their counts. It also generates the status bits that let software run a set-then-clear handshake with it. Each port takes its update request either from its own software control bit or from a shared source. The shared source is picked by a two-bit global mode from three options: a global software bit, a general-purpose input pin, or a one-second tick.

The chosen request for each port passes through a two-flop synchronizer. The synchronized level is the port's status bit. A single-cycle counter strobe fires on the rising edge of that status bit. A global status bit combines the status of every port that follows the shared source; ports that use their own software bit never affect it. Sticky flags on the per-port and global status rises can drive an interrupt that tells software the snapshot registers are ready. Software clears these flags with write-one-to-clear strobes.

Top module: `perf_update_sel`

## Requirements
- R1: With global mode 2'b00, the shared source is the global software bit, and the pin and the tick have no effect.
- R2: With global mode 2'b01, the shared source is the input pin, and the global software bit has no effect.
- R3: With global mode 2'b10 or 2'b11, the shared source is the one-second tick.
- R4: A port whose port-select bit is 0 follows its own software bit. A port whose port-select bit is 1 follows the shared source.
- R5: A port's status bit equals its selected request delayed by two clock cycles. It rises after the request rises and falls after the request falls, which supports the software set-then-clear handshake.
- R6: The counter strobe of a port is high for exactly one cycle, in the first cycle its status bit is high.
- R7: A port's latched flag becomes 1 in the cycle after its strobe. It holds until a write-one-to-clear pulse on that port's clear input, and it reads 0 in the cycle after that pulse.
- R8: The global status bit is the OR of the status bits of ports whose select bit is 1. Ports with select bit 0 are masked out.
- R9: The global latched flag becomes 1 in the cycle after the global status bit rises. It clears on its own write-one-to-clear pulse.
- R10: When a set and a clear of a latched flag happen in the same cycle, the flag becomes 1.
- R11: After reset, all status bits, strobes and latched flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gbl_mode | input | 2 | Shared source select: 00 software, 01 pin, 1x tick |
| gbl_sw_upd | input | 1 | Global software update bit |
| pin_upd | input | 1 | General-purpose input pin update request |
| sec_tick | input | 1 | One-second tick |
| port_glob_sel | input | NPORT | Per-port select: 0 own bit, 1 shared source |
| port_sw_upd | input | NPORT | Per-port software update bits |
| port_lat_clr | input | NPORT | Write-one-to-clear pulses for the per-port latched flags |
| gbl_lat_clr | input | 1 | Write-one-to-clear pulse for the global latched flag |
| cnt_strobe | output | NPORT | Single-cycle update-clear strobes to the counters |
| port_stat | output | NPORT | Per-port update status |
| port_stat_lat | output | NPORT | Per-port latched status flags |
| gbl_stat | output | 1 | Global update status |
| gbl_stat_lat | output | 1 | Global latched status flag |

## Verification
The assertions check on every cycle that each strobe lasts one cycle, that status edges trail the request by two cycles, and that latched flags set after a rise and hold until cleared. They also check that set wins over clear and that the global status stays low when no port selects the shared source. Source selection itself can only be shown by the bench's scenarios. Those scenarios cover each global mode, including the inputs a mode must ignore, the per-port choice between its own bit and the shared source, and the masking of own-bit ports out of the global status while they are active.

// File: rtl/pmu_sel_pkg.sv
package pmu_sel_pkg;

  typedef enum logic [1:0] {
    GSRC_SW       = 2'b00,
    GSRC_PIN      = 2'b01,
    GSRC_TICK     = 2'b10,
    GSRC_TICK_ALT = 2'b11
  } gsrc_mode_e;

  // Shared update source picked by the two-bit global mode.
  function automatic logic pick_shared(input logic [1:0] mode, input logic sw,
                                       input logic pin, input logic tick);
    logic r;
    case (gsrc_mode_e'(mode))
      GSRC_SW:  r = sw;
      GSRC_PIN: r = pin;
      default:  r = tick;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pmu_sync2.sv
module pmu_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] out_q, out_d;

  always_comb begin
    meta_d = d_i;
    out_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      out_q  <= '0;
    end else begin
      meta_q <= meta_d;
      out_q  <= out_d;
    end
  end

  assign q_o = out_q;
endmodule

// File: rtl/pmu_lane.sv
module pmu_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic lat_clr_i,
  output logic stat_o,
  output logic strobe_o,
  output logic lat_o
);
  logic sync_lvl;
  logic prev_q, prev_d;
  logic lat_q, lat_d;
  logic lat_en;

  pmu_sync2 #(.W(1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (sync_lvl)
  );

  assign strobe_o = sync_lvl & ~prev_q;
  assign stat_o   = sync_lvl;

  always_comb begin
    prev_d = sync_lvl;
    lat_en = strobe_o | lat_clr_i;
    lat_d  = strobe_o ? 1'b1 : 1'b0;   // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      if (lat_en) lat_q <= lat_d;
    end
  end

  assign lat_o = lat_q;

  AST_STAT_RISE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o) |-> $past(src_i, 2)); // R5
  AST_STAT_FALL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_o) |-> !$past(src_i, 2)); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o); // R6
  AST_LAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> lat_o); // R7
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lat_o && !lat_clr_i |=> lat_o); // R7
  AST_LAT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o && lat_clr_i |=> lat_o); // R10
endmodule

// File: rtl/pmu_gstat.sv
module pmu_gstat #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] stat_i,
  input  logic [NPORT-1:0] sel_i,
  input  logic             clr_i,
  output logic             gstat_o,
  output logic             glat_o
);
  logic prev_q, prev_d;
  logic glat_q, glat_d;
  logic glat_en;
  logic rise;

  assign gstat_o = |(stat_i & sel_i);
  assign rise    = gstat_o & ~prev_q;

  always_comb begin
    prev_d  = gstat_o;
    glat_en = rise | clr_i;
    glat_d  = rise ? 1'b1 : 1'b0;   // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      glat_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      if (glat_en) glat_q <= glat_d;
    end
  end

  assign glat_o = glat_q;

  AST_GBL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0) |-> !gstat_o); // R8
  AST_GLAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gstat_o) |=> glat_o); // R9
  AST_GLAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    glat_o && !clr_i |=> glat_o); // R9
endmodule

// File: rtl/perf_update_sel.sv
module perf_update_sel
  import pmu_sel_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       gbl_mode,
  input  logic             gbl_sw_upd,
  input  logic             pin_upd,
  input  logic             sec_tick,
  input  logic [NPORT-1:0] port_glob_sel,
  input  logic [NPORT-1:0] port_sw_upd,
  input  logic [NPORT-1:0] port_lat_clr,
  input  logic             gbl_lat_clr,
  output logic [NPORT-1:0] cnt_strobe,
  output logic [NPORT-1:0] port_stat,
  output logic [NPORT-1:0] port_stat_lat,
  output logic             gbl_stat,
  output logic             gbl_stat_lat
);
  logic             shared_src;
  logic [NPORT-1:0] lane_src;

  always_comb begin
    shared_src = pick_shared(gbl_mode, gbl_sw_upd, pin_upd, sec_tick);
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_lane
    assign lane_src[i] = port_glob_sel[i] ? shared_src : port_sw_upd[i];

    pmu_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (lane_src[i]),
      .lat_clr_i (port_lat_clr[i]),
      .stat_o    (port_stat[i]),
      .strobe_o  (cnt_strobe[i]),
      .lat_o     (port_stat_lat[i])
    );
  end

  pmu_gstat #(.NPORT(NPORT)) u_gstat (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_i  (port_stat),
    .sel_i   (port_glob_sel),
    .clr_i   (gbl_lat_clr),
    .gstat_o (gbl_stat),
    .glat_o  (gbl_stat_lat)
  );

  AST_OWN_PORTS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    gbl_stat |-> |(port_glob_sel & port_stat)); // R8
  AST_STROBE_IMPLIES_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_strobe & ~port_stat) == '0); // R6
endmodule

// File: tb/tb_perf_update_sel.sv
module tb_perf_update_sel;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   gbl_mode = 2'b00;
  logic         gbl_sw_upd = 1'b0;
  logic         pin_upd = 1'b0;
  logic         sec_tick = 1'b0;
  logic [N-1:0] port_glob_sel = '0;
  logic [N-1:0] port_sw_upd = '0;
  logic [N-1:0] port_lat_clr = '0;
  logic         gbl_lat_clr = 1'b0;
  logic [N-1:0] cnt_strobe, port_stat, port_stat_lat;
  logic         gbl_stat, gbl_stat_lat;

  perf_update_sel #(.NPORT(N)) dut (
    .clk(clk), .rst_n(rst_n), .gbl_mode(gbl_mode), .gbl_sw_upd(gbl_sw_upd),
    .pin_upd(pin_upd), .sec_tick(sec_tick), .port_glob_sel(port_glob_sel),
    .port_sw_upd(port_sw_upd), .port_lat_clr(port_lat_clr),
    .gbl_lat_clr(gbl_lat_clr), .cnt_strobe(cnt_strobe), .port_stat(port_stat),
    .port_stat_lat(port_stat_lat), .gbl_stat(gbl_stat), .gbl_stat_lat(gbl_stat_lat)
  );

  always #10 clk = ~clk;   // 50 MHz

  typedef enum int { F_STAT, F_STRB, F_SLAT, F_GSTAT, F_GLAT } fld_e;
  typedef struct {
    int          cyc;
    fld_e        fld;
    logic [N-1:0] exp;
    string       req;
  } item_t;

  item_t queue_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [N-1:0] observe(fld_e f);
    case (f)
      F_STAT:  return port_stat;
      F_STRB:  return cnt_strobe;
      F_SLAT:  return port_stat_lat;
      F_GSTAT: return {{(N-1){1'b0}}, gbl_stat};
      default: return {{(N-1){1'b0}}, gbl_stat_lat};
    endcase
  endfunction

  function automatic void compare(fld_e f, logic [N-1:0] exp, string req);
    logic [N-1:0] act = observe(f);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: field %s actual=%b expected=%b at cycle %0d",
               req, f.name(), act, exp, cyc);
    end
  endfunction

  // driver side: schedule an expected value d cycles from now
  task automatic expect_in(int d, fld_e f, logic [N-1:0] exp, string req);
    item_t it;
    it.cyc = cyc + d; it.fld = f; it.exp = exp; it.req = req;
    queue_q.push_back(it);
  endtask

  // monitor: pop and compare items that fall due
  always @(negedge clk) begin
    for (int i = queue_q.size() - 1; i >= 0; i--) begin
      if (queue_q[i].cyc == cyc) begin
        compare(queue_q[i].fld, queue_q[i].exp, queue_q[i].req);
        queue_q.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (queue_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", queue_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11 reset state
    compare(F_STAT, '0, "R11");
    compare(F_STRB, '0, "R11");
    compare(F_SLAT, '0, "R11");
    compare(F_GSTAT, '0, "R11");
    compare(F_GLAT, '0, "R11");

    // R4/R5/R6/R7/R8: own-bit ports, software handshake
    port_sw_upd = 4'b1001;
    expect_in(1, F_STAT, 4'b0000, "R5");
    expect_in(2, F_STAT, 4'b1001, "R4");
    expect_in(2, F_STRB, 4'b1001, "R6");
    expect_in(3, F_STRB, 4'b0000, "R6");
    expect_in(3, F_SLAT, 4'b1001, "R7");
    expect_in(2, F_GSTAT, 4'b0000, "R8");
    expect_in(3, F_GLAT, 4'b0000, "R8");
    step(4);
    port_sw_upd = 4'b0000;
    expect_in(1, F_STAT, 4'b1001, "R5");
    expect_in(2, F_STAT, 4'b0000, "R5");
    expect_in(4, F_SLAT, 4'b1001, "R7");
    step(5);
    port_lat_clr = 4'b0001;
    expect_in(1, F_SLAT, 4'b1000, "R7");
    step(1);
    port_lat_clr = 4'b1000;
    expect_in(1, F_SLAT, 4'b0000, "R7");
    step(1);
    port_lat_clr = '0;
    step(2);

    // R2: pin mode, global software bit ignored
    port_glob_sel = 4'b0110;
    gbl_mode = 2'b01;
    step(3);
    gbl_sw_upd = 1'b1;
    sec_tick = 1'b1;
    expect_in(2, F_STAT, 4'b0000, "R2");
    expect_in(3, F_GSTAT, 4'b0000, "R2");
    step(4);
    pin_upd = 1'b1;
    expect_in(2, F_STAT, 4'b0110, "R2");
    expect_in(2, F_STRB, 4'b0110, "R6");
    expect_in(2, F_GSTAT, 4'b0001, "R8");
    expect_in(3, F_GLAT, 4'b0001, "R9");
    expect_in(3, F_SLAT, 4'b0110, "R7");
    step(4);
    pin_upd = 1'b0;
    gbl_sw_upd = 1'b0;
    sec_tick = 1'b0;
    expect_in(2, F_STAT, 4'b0000, "R2");
    expect_in(2, F_GSTAT, 4'b0000, "R8");
    expect_in(4, F_GLAT, 4'b0001, "R9");
    step(5);
    gbl_lat_clr = 1'b1;
    port_lat_clr = '1;
    expect_in(1, F_GLAT, 4'b0000, "R9");
    expect_in(1, F_SLAT, 4'b0000, "R7");
    step(1);
    gbl_lat_clr = 1'b0;
    port_lat_clr = '0;
    step(2);

    // R3: tick mode 10, one-cycle tick
    gbl_mode = 2'b10;
    step(1);
    sec_tick = 1'b1;
    expect_in(2, F_STAT, 4'b0110, "R3");
    expect_in(3, F_STAT, 4'b0000, "R3");
    expect_in(2, F_STRB, 4'b0110, "R6");
    expect_in(3, F_STRB, 4'b0000, "R6");
    step(1);
    sec_tick = 1'b0;
    step(5);
    gbl_lat_clr = 1'b1;
    port_lat_clr = '1;
    expect_in(1, F_GLAT, 4'b0000, "R9");
    expect_in(1, F_SLAT, 4'b0000, "R7");
    step(1);
    gbl_lat_clr = 1'b0;
    port_lat_clr = '0;
    step(2);

    // R3 + R10: tick mode 11, clear coincides with set
    gbl_mode = 2'b11;
    step(1);
    sec_tick = 1'b1;
    expect_in(2, F_STAT, 4'b0110, "R3");
    expect_in(2, F_GSTAT, 4'b0001, "R3");
    expect_in(3, F_SLAT, 4'b0110, "R10");
    expect_in(3, F_GLAT, 4'b0001, "R10");
    step(1);
    sec_tick = 1'b0;
    step(1);
    gbl_lat_clr = 1'b1;
    port_lat_clr = '1;
    step(1);
    gbl_lat_clr = 1'b0;
    port_lat_clr = '0;
    step(4);
    gbl_lat_clr = 1'b1;
    port_lat_clr = '1;
    step(1);
    gbl_lat_clr = 1'b0;
    port_lat_clr = '0;
    step(2);

    // R1: software mode, pin and tick ignored
    gbl_mode = 2'b00;
    step(1);
    pin_upd = 1'b1;
    sec_tick = 1'b1;
    expect_in(2, F_STAT, 4'b0000, "R1");
    expect_in(3, F_GLAT, 4'b0000, "R1");
    step(4);
    pin_upd = 1'b0;
    sec_tick = 1'b0;
    gbl_sw_upd = 1'b1;
    expect_in(2, F_STAT, 4'b0110, "R1");
    expect_in(2, F_GSTAT, 4'b0001, "R1");
    step(4);

    // R4: port 0 switches to the shared source, which is high
    port_glob_sel = 4'b0111;
    expect_in(2, F_STAT, 4'b0111, "R4");
    expect_in(2, F_STRB, 4'b0001, "R4");
    step(4);
    gbl_sw_upd = 1'b0;
    expect_in(2, F_STAT, 4'b0000, "R5");
    expect_in(2, F_GSTAT, 4'b0000, "R8");
    step(5);

    done = 1;
    finish_run();
  end
endmodule